// File: doc/BRIEF.md
# Predicate Register File with Commit Gate

This block keeps the one-bit guard conditions for a predicated pipeline and decides, for every retiring instruction, whether its result reaches the general-purpose register file. A compare operation sets a pair of guards in one step: one takes the condition and the other takes its inverse. Both arms of an if/else can then be guarded by the pair, with no branch.

Each retiring instruction gives a guard index, a destination write request, its result and the old value of its destination. With a false guard an ordinary instruction becomes a NOP: no write and no commit. In conditional-move mode the destination is always written, with the new value when the guard is true and the old value when it is false. Guard 0 always reads true, so unguarded code names it. A compare in the same cycle forwards its new values to the instruction that reads them.

The gate is combinational from the instruction inputs to the write port. The guard file is the only state, and it updates on the clock edge that ends a compare cycle. There is no sequencing controller, so the block has no named states or transitions.

Top module: `pred_commit_gate`

## Requirements
- R1: After reset every guard register reads false except guard 0, which reads true.
- R2: Guard 0 always reads true. A compare that names index 0 as either destination leaves it true and still writes its other destination.
- R3: A compare (cmp_valid=1) writes cmp_cond into guard cmp_dst_t and the inverse of cmp_cond into guard cmp_dst_f. Instructions see the new values from the next cycle on.
- R4: If cmp_dst_t equals cmp_dst_f, that guard takes the inverse of cmp_cond.
- R5: An instruction that reads a guard written by a compare in the same cycle sees the new value.
- R6: With ins_cmov=0 and a false guard, wr_en and commit are both 0.
- R7: With ins_cmov=0 and a true guard, commit=1, wr_en equals ins_wen and wr_data equals ins_result.
- R8: With ins_cmov=1, wr_en equals ins_wen and commit equals the guard. wr_data is ins_result if the guard is true and ins_old if it is false.
- R9: With ins_valid=0, wr_en and commit are both 0.
- R10: A guard register keeps its value until a compare names it as a destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_valid | input | 1 | A compare writes guards this cycle |
| cmp_cond | input | 1 | Outcome of the compare |
| cmp_dst_t | input | 6 | Guard that receives the outcome |
| cmp_dst_f | input | 6 | Guard that receives the inverted outcome |
| ins_valid | input | 1 | A retiring instruction is present |
| ins_pidx | input | 6 | Index of the instruction's guard |
| ins_wen | input | 1 | The instruction requests a register write |
| ins_cmov | input | 1 | Conditional-move mode |
| ins_result | input | 32 | New value computed by the instruction |
| ins_old | input | 32 | Current value of the destination register |
| commit | output | 1 | The instruction takes architectural effect |
| wr_en | output | 1 | Register-file write enable |
| wr_data | output | 32 | Register-file write data |

## Verification
commit, wr_en and wr_data are due in the same cycle as the instruction inputs, because the path to them has no register. A compare changes the guard file at the next rising edge. The bench drives each step on the falling edge, samples the outputs 1 ns later while the inputs are still stable, and updates its own guard model only after that sample. A read in the compare cycle is therefore checked against the forwarded value, and later reads against the stored one.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
    localparam int PCG_NPRED = 64;
    localparam int PCG_WIDTH = 32;
endpackage

// File: rtl/pcg_pred_file.sv
module pcg_pred_file #(
    parameter int NPRED = 64,
    parameter int IW    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic             wr_cond,
    input  logic [IW-1:0]    wr_idx_t,
    input  logic [IW-1:0]    wr_idx_f,
    output logic [NPRED-1:0] state_q
);
    // guard 0 is a constant true; writes to it are dropped
    assign state_q[0] = 1'b1;

    for (genvar gi = 1; gi < NPRED; gi++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bit_q <= 1'b0;
            end else if (wr_valid && (wr_idx_f == IW'(gi))) begin
                // inverted destination checked first: it wins on a collision
                bit_q <= ~wr_cond;
            end else if (wr_valid && (wr_idx_t == IW'(gi))) begin
                bit_q <= wr_cond;
            end
        end
        assign state_q[gi] = bit_q;
    end
endmodule

// File: rtl/pcg_pred_read.sv
module pcg_pred_read #(
    parameter int NPRED = 64,
    parameter int IW    = 6
) (
    input  logic [NPRED-1:0] state,
    input  logic [IW-1:0]    rd_idx,
    input  logic             byp_valid,
    input  logic             byp_cond,
    input  logic [IW-1:0]    byp_t,
    input  logic [IW-1:0]    byp_f,
    output logic             pred_o
);
    logic not_zero;
    assign not_zero = (rd_idx != '0);

    always_comb begin
        if (byp_valid && not_zero && (rd_idx == byp_f)) begin
            pred_o = ~byp_cond;
        end else if (byp_valid && not_zero && (rd_idx == byp_t)) begin
            pred_o = byp_cond;
        end else begin
            pred_o = state[rd_idx];
        end
    end
endmodule

// File: rtl/pcg_commit_sel.sv
module pcg_commit_sel #(
    parameter int W = 32
) (
    input  logic         valid,
    input  logic         wen,
    input  logic         cmov,
    input  logic         pred,
    input  logic [W-1:0] result,
    input  logic [W-1:0] old,
    output logic         commit,
    output logic         wr_en,
    output logic [W-1:0] wr_data
);
    always_comb begin
        commit = valid && pred;
        if (cmov) begin
            wr_en   = valid && wen;
            wr_data = pred ? result : old;
        end else begin
            wr_en   = valid && wen && pred;
            wr_data = result;
        end
    end
endmodule

// File: rtl/pred_commit_gate.sv
module pred_commit_gate #(
    parameter int NPRED = pcg_pkg::PCG_NPRED,
    parameter int W     = pcg_pkg::PCG_WIDTH,
    localparam int IW   = $clog2(NPRED)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmp_valid,
    input  logic          cmp_cond,
    input  logic [IW-1:0] cmp_dst_t,
    input  logic [IW-1:0] cmp_dst_f,
    input  logic          ins_valid,
    input  logic [IW-1:0] ins_pidx,
    input  logic          ins_wen,
    input  logic          ins_cmov,
    input  logic [W-1:0]  ins_result,
    input  logic [W-1:0]  ins_old,
    output logic          commit,
    output logic          wr_en,
    output logic [W-1:0]  wr_data
);
    logic [NPRED-1:0] guard_vec;
    logic             guard_now;

    pcg_pred_file #(.NPRED(NPRED), .IW(IW)) u_file (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (cmp_valid),
        .wr_cond  (cmp_cond),
        .wr_idx_t (cmp_dst_t),
        .wr_idx_f (cmp_dst_f),
        .state_q  (guard_vec)
    );

    pcg_pred_read #(.NPRED(NPRED), .IW(IW)) u_read (
        .state     (guard_vec),
        .rd_idx    (ins_pidx),
        .byp_valid (cmp_valid),
        .byp_cond  (cmp_cond),
        .byp_t     (cmp_dst_t),
        .byp_f     (cmp_dst_f),
        .pred_o    (guard_now)
    );

    pcg_commit_sel #(.W(W)) u_sel (
        .valid   (ins_valid),
        .wen     (ins_wen),
        .cmov    (ins_cmov),
        .pred    (guard_now),
        .result  (ins_result),
        .old     (ins_old),
        .commit  (commit),
        .wr_en   (wr_en),
        .wr_data (wr_data)
    );
endmodule

// File: rtl/pred_commit_gate_chk.sv
module pred_commit_gate_chk #(
    parameter int NPRED = 64,
    parameter int W     = 32,
    localparam int IW   = $clog2(NPRED)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmp_valid,
    input logic          cmp_cond,
    input logic [IW-1:0] cmp_dst_t,
    input logic [IW-1:0] cmp_dst_f,
    input logic          ins_valid,
    input logic [IW-1:0] ins_pidx,
    input logic          ins_wen,
    input logic          ins_cmov,
    input logic [W-1:0]  ins_result,
    input logic [W-1:0]  ins_old,
    input logic          commit,
    input logic          wr_en,
    input logic [W-1:0]  wr_data
);
    logic armed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    logic cur_hits;
    assign cur_hits = cmp_valid && ((ins_pidx == cmp_dst_t) || (ins_pidx == cmp_dst_f));

    a_r2_zero_true: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid && (ins_pidx == '0) |-> commit);

    a_r3_pair_write: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(cmp_valid && (cmp_dst_t != '0) && (cmp_dst_t != cmp_dst_f))
        && ins_valid && (ins_pidx == $past(cmp_dst_t)) && !cur_hits
        |-> commit == $past(cmp_cond));

    a_r4_same_dst: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(cmp_valid && (cmp_dst_t != '0) && (cmp_dst_t == cmp_dst_f))
        && ins_valid && (ins_pidx == $past(cmp_dst_t)) && !cur_hits
        |-> commit == !$past(cmp_cond));

    a_r6_false_nop: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid && !ins_cmov && !commit |-> !wr_en);

    a_r7_true_writes: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid && !ins_cmov && commit |-> (wr_en == ins_wen) && (wr_data == ins_result));

    a_r8_cmov_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid && ins_cmov && !commit |-> (wr_en == ins_wen) && (wr_data == ins_old));

    a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !ins_valid |-> !wr_en && !commit);
endmodule

bind pred_commit_gate pred_commit_gate_chk #(.NPRED(NPRED), .W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmp_valid  (cmp_valid),
    .cmp_cond   (cmp_cond),
    .cmp_dst_t  (cmp_dst_t),
    .cmp_dst_f  (cmp_dst_f),
    .ins_valid  (ins_valid),
    .ins_pidx   (ins_pidx),
    .ins_wen    (ins_wen),
    .ins_cmov   (ins_cmov),
    .ins_result (ins_result),
    .ins_old    (ins_old),
    .commit     (commit),
    .wr_en      (wr_en),
    .wr_data    (wr_data)
);

// File: tb/pred_commit_gate_bench.sv
`timescale 1ns/1ps
module pred_commit_gate_bench;
    localparam int NP = 64;
    localparam int W  = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmp_valid = 1'b0, cmp_cond = 1'b0;
    logic [5:0]    cmp_dst_t = '0, cmp_dst_f = '0;
    logic          ins_valid = 1'b0, ins_wen = 1'b0, ins_cmov = 1'b0;
    logic [5:0]    ins_pidx = '0;
    logic [W-1:0]  ins_result = '0, ins_old = '0;
    logic          commit, wr_en;
    logic [W-1:0]  wr_data;

    int total = 0;
    int bad   = 0;
    logic model [NP];

    always #5 clk = ~clk;

    pred_commit_gate u_pred_commit_gate (
        .clk(clk), .rst_n(rst_n),
        .cmp_valid(cmp_valid), .cmp_cond(cmp_cond),
        .cmp_dst_t(cmp_dst_t), .cmp_dst_f(cmp_dst_f),
        .ins_valid(ins_valid), .ins_pidx(ins_pidx), .ins_wen(ins_wen),
        .ins_cmov(ins_cmov), .ins_result(ins_result), .ins_old(ins_old),
        .commit(commit), .wr_en(wr_en), .wr_data(wr_data)
    );

    // guard value as the requirements define it (R2, R4, R5)
    function automatic logic expect_guard(logic [5:0] idx);
        if (idx == 0) return 1'b1;
        if (cmp_valid && idx == cmp_dst_f) return ~cmp_cond;
        if (cmp_valid && idx == cmp_dst_t) return cmp_cond;
        return model[idx];
    endfunction

    // one cycle: drive at falling edge, check 1 ns later, model updates at the edge
    task automatic step(input logic cv, input logic cc, input logic [5:0] ct, input logic [5:0] cf,
                        input logic iv, input logic [5:0] ip, input logic iw, input logic im,
                        input logic [W-1:0] res, input logic [W-1:0] old, input string req);
        logic g, e_commit, e_wen;
        logic [W-1:0] e_data;
        @(negedge clk);
        cmp_valid = cv; cmp_cond = cc; cmp_dst_t = ct; cmp_dst_f = cf;
        ins_valid = iv; ins_pidx = ip; ins_wen = iw; ins_cmov = im;
        ins_result = res; ins_old = old;
        #1;
        g        = expect_guard(ip);
        e_commit = iv & g;
        e_wen    = im ? (iv & iw) : (iv & iw & g);
        e_data   = (im && !g) ? old : res;
        total++;
        if (commit !== e_commit || wr_en !== e_wen || (e_wen && wr_data !== e_data)) begin
            bad++;
            $display("FAIL %s: idx=%0d commit=%b/%b wr_en=%b/%b data=%h/%h (actual/expected)",
                     req, ip, commit, e_commit, wr_en, e_wen, wr_data, e_data);
        end
        if (cv) begin
            if (ct != 0) model[ct] = cc;
            if (cf != 0) model[cf] = ~cc;
        end
    endtask

    initial begin
        #2000000;
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NP; i++) model[i] = (i == 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values of every guard
        for (int i = 0; i < NP; i++)
            step(0, 0, 0, 0, 1, 6'(i), 1, 0, 32'(i * 7 + 1), 32'hDEAD, "R1");

        // R3/R5: pair writes, reader hits the guard in the same cycle
        for (int i = 1; i < 32; i++)
            step(1, i[0], 6'(i), 6'(i + 32), 1, 6'(i + (i % 2) * 32), 1, 0, 32'(i), 32'h0, "R5");
        // R3/R10: read back every guard
        for (int i = 0; i < NP; i++)
            step(0, 0, 0, 0, 1, 6'(i), 1, 0, 32'(i ^ 32'h55), 32'h1, "R3_R10");

        // R2: compares aimed at guard 0
        step(1, 1, 0, 5, 1, 0, 1, 0, 32'hA0, 32'h0, "R2");
        step(0, 0, 0, 0, 1, 0, 1, 0, 32'hA1, 32'h0, "R2");
        step(0, 0, 0, 0, 1, 5, 1, 0, 32'hA2, 32'h0, "R2");
        step(1, 0, 5, 0, 1, 0, 1, 1, 32'hA3, 32'hB3, "R2");
        step(0, 0, 0, 0, 1, 5, 1, 0, 32'hA4, 32'h0, "R2");

        // R4: same destination twice, inverted value wins
        step(1, 1, 7, 7, 1, 7, 1, 0, 32'hC0, 32'h0, "R4");
        step(0, 0, 0, 0, 1, 7, 1, 0, 32'hC1, 32'h0, "R4");
        step(1, 0, 7, 7, 1, 7, 1, 0, 32'hC2, 32'h0, "R4");
        step(0, 0, 0, 0, 1, 7, 1, 0, 32'hC3, 32'h0, "R4");

        // R10: unrelated compare leaves guard 9 alone
        step(1, 1, 20, 21, 1, 9, 1, 0, 32'hD0, 32'h0, "R10");

        // R6..R9: every control combination over true and false guards
        for (int k = 0; k < 4; k++) begin
            for (int c = 0; c < 8; c++) begin
                logic [5:0] gi;
                gi = (k == 0) ? 6'd0 : (k == 1) ? 6'd7 : (k == 2) ? 6'd1 : 6'd33;
                step(0, 0, 0, 0, c[2], gi, c[1], c[0],
                     32'h1000 + 32'(k * 8 + c), 32'h2000 + 32'(k * 8 + c), "R6_R7_R8_R9");
            end
        end

        // R8: conditional move while the guard is being forwarded
        step(1, 0, 40, 41, 1, 40, 1, 1, 32'hE0, 32'hF0, "R8");
        step(1, 0, 40, 41, 1, 41, 1, 1, 32'hE1, 32'hF1, "R8");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule